// File: doc/BRIEF.md
# Byte FIFO with Word Access Port

This block buffers data between a 32-bit software register port and a byte-wide serial shifter. Software moves whole words through one access location: a write strobe appends four bytes and a read strobe removes four. The shifter adds or removes one byte at a time. Occupancy is counted in bytes. The block reports both the number of stored bytes and the free space. Bytes are packed little-endian. The low byte of a written word is the first byte the shifter receives. The first byte the shifter delivers lands in the low byte of the next word software reads.

Capacity depends on the duplex mode input: the full `DEPTH` (128 bytes by default) in half-duplex and half of it in full-duplex. Any change of mode empties the buffer. Word accesses that cannot complete are refused and leave the contents untouched. Each refused access raises a one-cycle event: an underflow, an overflow, or an access in the wrong direction for the command in progress. Two level flags compare the occupancy and the free space against programmable thresholds.

The shifter side uses valid/ready handshakes. A byte moves only in a cycle where both valid and ready are high. `rx_ready` is dropped while the buffer is full, while a mode flush is pending, or while software is writing a word in the same cycle. `tx_valid` is dropped while the buffer is empty, while a flush is pending, or while software is reading a word in the same cycle. When ready or valid is low, the shifter must hold its byte and try again in a later cycle.

Top module: `byte_word_fifo`

## Requirements
- R1: After reset the buffer is empty: `byte_count` is 0, `space_left` is 128, and every event output is low.
- R2: `byte_count` equals the number of bytes stored. Capacity is 128 bytes when `duplex_full` is 0 and 64 bytes when it is 1.
- R3: `space_left` always equals the capacity minus `byte_count`.
- R4: A software word read while fewer than 4 bytes are stored is refused. The buffer is left unchanged and `ev_underflow` is high in the cycle after the strobe.
- R5: A software word write while more than capacity minus 4 bytes are stored is refused. The buffer is left unchanged and `ev_overflow` is high in the cycle after the strobe.
- R6: The direction of the active command is given by `cmd_dir`: 0 means read, 1 means write. While `cmd_active` is 1, a software write with `cmd_dir`=0, or a software read with `cmd_dir`=1, is refused and pulses `ev_illegal` in the next cycle.
- R7: Packing is little-endian. `sw_wdata[7:0]` is the first byte to leave on `tx_byte`. The first byte accepted on `rx_byte` appears in `sw_rdata[7:0]`. `sw_rdata` always shows the four oldest bytes.
- R8: `thr_rd` is high exactly when `byte_count` is at or above `rd_thresh`. `thr_wr` is high exactly when `space_left` is at or above `wr_thresh`.
- R9: When `duplex_full` differs from the current mode, the buffer is emptied on the next edge and any access made in that cycle is dropped without an event.
- R10: `rx_ready` is high only when no flush is pending, `sw_wr_en` is low, and the buffer is not full. `tx_valid` is high only when no flush is pending, `sw_rd_en` is low, and the buffer is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duplex_full | input | 1 | 1 selects full-duplex mode (half capacity) |
| cmd_active | input | 1 | A command is in progress |
| cmd_dir | input | 1 | Direction of the active command: 0 read, 1 write |
| sw_wr_en | input | 1 | Software word write strobe |
| sw_wdata | input | 32 | Word to append |
| sw_rd_en | input | 1 | Software word read strobe (removes the head word) |
| sw_rdata | output | 32 | Four oldest bytes, little-endian |
| rx_valid | input | 1 | Shifter offers a received byte |
| rx_ready | output | 1 | Buffer accepts the offered byte |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | A byte is available for the shifter |
| tx_ready | input | 1 | Shifter takes the byte |
| tx_byte | output | 8 | Oldest stored byte |
| rd_thresh | input | 8 | Occupancy threshold |
| wr_thresh | input | 8 | Free-space threshold |
| byte_count | output | 8 | Bytes stored |
| space_left | output | 8 | Bytes free |
| thr_rd | output | 1 | Occupancy at or above `rd_thresh` |
| thr_wr | output | 1 | Free space at or above `wr_thresh` |
| ev_underflow | output | 1 | Refused word read pulse |
| ev_overflow | output | 1 | Refused word write pulse |
| ev_illegal | output | 1 | Wrong-direction access pulse |

## Verification
The results arrive at different times:
- A strobe or handshake applied before a rising edge changes `byte_count`, `space_left`, `sw_rdata` and the event pulses just after that edge.
- The threshold flags, `rx_ready` and `tx_valid` are combinational functions of the inputs and the stored count.
- A mode change shows an empty buffer and the new capacity one edge after `duplex_full` moves.

The bench drives stimulus on the falling edge. It checks the handshake outputs and the head word in the same half cycle, before the rising edge. It checks counts and events one time step after that rising edge. The threshold sweep changes only the threshold inputs and compares the flags without any clock edge in between.

// File: rtl/bwf_pkg.sv
package bwf_pkg;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } cmd_dir_e;

  // circular index advance with a run-time limit
  function automatic int unsigned wrap_add(int unsigned p, int unsigned k, int unsigned lim);
    return (p + k >= lim) ? p + k - lim : p + k;
  endfunction

endpackage

// File: rtl/bwf_store.sv
module bwf_store #(
  parameter int DEPTH = 128,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          word_we,
  input  logic          byte_we,
  input  logic [PW-1:0] waddr,
  input  logic [PW-1:0] raddr,
  input  logic [PW:0]   cap,
  input  logic [31:0]   wword,
  input  logic [7:0]    wbyte,
  output logic [31:0]   head_word,
  output logic [7:0]    head_byte
);
  import bwf_pkg::*;

  localparam int LANES = 4;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wa [LANES];
  logic [PW-1:0] ra [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wa[i] = PW'(wrap_add(int'(waddr), i, int'(cap)));
    assign ra[i] = PW'(wrap_add(int'(raddr), i, int'(cap)));
    assign head_word[8*i +: 8] = mem[ra[i]];
  end

  assign head_byte = mem[raddr];

  always_ff @(posedge clk) begin
    if (word_we) begin
      for (int i = 0; i < LANES; i++) mem[wa[i]] <= wword[8*i +: 8];
    end else if (byte_we) begin
      mem[waddr] <= wbyte;
    end
  end

endmodule

// File: rtl/bwf_ctrl.sv
module bwf_ctrl #(
  parameter int DEPTH = 128,
  parameter int PW    = $clog2(DEPTH),
  parameter int CW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          duplex_full,
  input  logic          cmd_active,
  input  logic          cmd_dir,
  input  logic          sw_wr_en,
  input  logic          sw_rd_en,
  input  logic          rx_valid,
  input  logic          tx_ready,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic          word_we,
  output logic          byte_we,
  output logic [PW-1:0] waddr,
  output logic [PW-1:0] raddr,
  output logic [CW-1:0] cap,
  output logic [CW-1:0] count,
  output logic          mode_q,
  output logic          ev_underflow,
  output logic          ev_overflow,
  output logic          ev_illegal
);
  import bwf_pkg::*;

  localparam int WB = 4;

  logic flush, wr_bad, rd_bad, wr_ovf, rd_unf, word_re, byte_re;
  logic [PW-1:0] wptr_n, rptr_n;
  logic [CW-1:0] count_n;

  assign flush   = (duplex_full != mode_q);
  assign cap     = mode_q ? CW'(DEPTH / 2) : CW'(DEPTH);
  assign wr_bad  = cmd_active && (cmd_dir_e'(cmd_dir) == DIR_READ);
  assign rd_bad  = cmd_active && (cmd_dir_e'(cmd_dir) == DIR_WRITE);
  assign wr_ovf  = count > (cap - CW'(WB));
  assign rd_unf  = count < CW'(WB);

  assign word_we = sw_wr_en && !flush && !wr_bad && !wr_ovf;
  assign word_re = sw_rd_en && !flush && !rd_bad && !rd_unf;
  assign rx_ready = !flush && !sw_wr_en && (count < cap);
  assign tx_valid = !flush && !sw_rd_en && (count != '0);
  assign byte_we = rx_valid && rx_ready;
  assign byte_re = tx_valid && tx_ready;

  always_comb begin
    wptr_n  = waddr;
    rptr_n  = raddr;
    count_n = count;
    if (word_we) begin
      wptr_n  = PW'(wrap_add(int'(waddr), WB, int'(cap)));
      count_n = count_n + CW'(WB);
    end else if (byte_we) begin
      wptr_n  = PW'(wrap_add(int'(waddr), 1, int'(cap)));
      count_n = count_n + CW'(1);
    end
    if (word_re) begin
      rptr_n  = PW'(wrap_add(int'(raddr), WB, int'(cap)));
      count_n = count_n - CW'(WB);
    end else if (byte_re) begin
      rptr_n  = PW'(wrap_add(int'(raddr), 1, int'(cap)));
      count_n = count_n - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr        <= '0;
      raddr        <= '0;
      count        <= '0;
      mode_q       <= 1'b0;
      ev_underflow <= 1'b0;
      ev_overflow  <= 1'b0;
      ev_illegal   <= 1'b0;
    end else begin
      ev_underflow <= sw_rd_en && !flush && !rd_bad && rd_unf;
      ev_overflow  <= sw_wr_en && !flush && !wr_bad && wr_ovf;
      ev_illegal   <= !flush && ((sw_wr_en && wr_bad) || (sw_rd_en && rd_bad));
      if (flush) begin
        mode_q <= duplex_full;
        waddr  <= '0;
        raddr  <= '0;
        count  <= '0;
      end else begin
        waddr  <= wptr_n;
        raddr  <= rptr_n;
        count  <= count_n;
      end
    end
  end

endmodule

// File: rtl/byte_word_fifo.sv
module byte_word_fifo #(
  parameter int DEPTH = 128,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          duplex_full,
  input  logic          cmd_active,
  input  logic          cmd_dir,
  input  logic          sw_wr_en,
  input  logic [31:0]   sw_wdata,
  input  logic          sw_rd_en,
  output logic [31:0]   sw_rdata,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_byte,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_byte,
  input  logic [CW-1:0] rd_thresh,
  input  logic [CW-1:0] wr_thresh,
  output logic [CW-1:0] byte_count,
  output logic [CW-1:0] space_left,
  output logic          thr_rd,
  output logic          thr_wr,
  output logic          ev_underflow,
  output logic          ev_overflow,
  output logic          ev_illegal
);

  logic          word_we, byte_we, mode_q;
  logic [PW-1:0] waddr, raddr;
  logic [CW-1:0] cap;

  bwf_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .duplex_full(duplex_full),
    .cmd_active(cmd_active), .cmd_dir(cmd_dir),
    .sw_wr_en(sw_wr_en), .sw_rd_en(sw_rd_en),
    .rx_valid(rx_valid), .tx_ready(tx_ready),
    .rx_ready(rx_ready), .tx_valid(tx_valid),
    .word_we(word_we), .byte_we(byte_we),
    .waddr(waddr), .raddr(raddr), .cap(cap), .count(byte_count),
    .mode_q(mode_q), .ev_underflow(ev_underflow),
    .ev_overflow(ev_overflow), .ev_illegal(ev_illegal)
  );

  bwf_store #(.DEPTH(DEPTH), .PW(PW)) u_store (
    .clk(clk), .word_we(word_we), .byte_we(byte_we),
    .waddr(waddr), .raddr(raddr), .cap(cap),
    .wword(sw_wdata), .wbyte(rx_byte),
    .head_word(sw_rdata), .head_byte(tx_byte)
  );

  assign space_left = cap - byte_count;
  assign thr_rd     = byte_count >= rd_thresh;
  assign thr_wr     = space_left >= wr_thresh;

endmodule

// File: rtl/bwf_checker.sv
module bwf_checker #(
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          duplex_full,
  input logic          mode_q,
  input logic          cmd_active,
  input logic          cmd_dir,
  input logic          sw_wr_en,
  input logic          sw_rd_en,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic [CW-1:0] byte_count,
  input logic [CW-1:0] space_left,
  input logic          ev_underflow,
  input logic          ev_overflow,
  input logic          ev_illegal
);

  logic [CW:0] cap_c;
  logic        steady;
  assign cap_c  = mode_q ? (CW+1)'(DEPTH / 2) : (CW+1)'(DEPTH);
  assign steady = (duplex_full == mode_q);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (CW+1)'(byte_count) <= cap_c);

  p_space_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((CW+1)'(byte_count) + (CW+1)'(space_left)) == cap_c);

  p_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd_en && steady && !(cmd_active && cmd_dir) && byte_count < CW'(4))
    |=> ev_underflow);

  p_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && steady && !(cmd_active && !cmd_dir) &&
     (CW+1)'(byte_count) + 4 > cap_c) |=> ev_overflow);

  p_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && cmd_active && ((sw_wr_en && !cmd_dir) || (sw_rd_en && cmd_dir)))
    |=> ev_illegal);

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !steady |=> (byte_count == '0));

  p_handshake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready |-> ((CW+1)'(byte_count) < cap_c && !sw_wr_en)) and
    (tx_valid |-> (byte_count != '0 && !sw_rd_en)));

endmodule

bind byte_word_fifo bwf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .duplex_full(duplex_full), .mode_q(mode_q),
  .cmd_active(cmd_active), .cmd_dir(cmd_dir),
  .sw_wr_en(sw_wr_en), .sw_rd_en(sw_rd_en),
  .rx_ready(rx_ready), .tx_valid(tx_valid),
  .byte_count(byte_count), .space_left(space_left),
  .ev_underflow(ev_underflow), .ev_overflow(ev_overflow), .ev_illegal(ev_illegal)
);

// File: tb/sim_byte_word_fifo.sv
`timescale 1ns/1ps
module sim_byte_word_fifo;

  logic clk = 1'b0, rst_n = 1'b0;
  logic duplex_full = 0, cmd_active = 0, cmd_dir = 0;
  logic sw_wr_en = 0, sw_rd_en = 0, rx_valid = 0, tx_ready = 0;
  logic [31:0] sw_wdata = '0, sw_rdata;
  logic [7:0] rx_byte = '0, tx_byte, rd_thresh = 8'd16, wr_thresh = 8'd40;
  logic [7:0] byte_count, space_left;
  logic rx_ready, tx_valid, thr_rd, thr_wr, ev_underflow, ev_overflow, ev_illegal;

  int checks = 0, errors = 0, cap = 128;
  logic [7:0] q[$];

  always #4 clk = ~clk;

  byte_word_fifo u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_state(input string tag);
    chk(int'(byte_count) == q.size(), {tag, " R2 count"}, byte_count, q.size());
    chk(int'(space_left) == cap - q.size(), {tag, " R3 space"}, space_left, cap - q.size());
    chk(thr_rd == (q.size() >= int'(rd_thresh)), {tag, " R8 rd"}, thr_rd, q.size() >= int'(rd_thresh));
    chk(thr_wr == (cap - q.size() >= int'(wr_thresh)), {tag, " R8 wr"}, thr_wr,
        cap - q.size() >= int'(wr_thresh));
  endtask

  task automatic sw_write(input logic [31:0] w);
    bit bad, ovf;
    @(negedge clk);
    bad = cmd_active && !cmd_dir;
    ovf = !bad && (q.size() > cap - 4);
    sw_wr_en = 1; sw_wdata = w;
    #1 chk(rx_ready == 0, "R10 rx_ready during word write", rx_ready, 0);
    @(posedge clk); #1;
    sw_wr_en = 0;
    if (!bad && !ovf) for (int i = 0; i < 4; i++) q.push_back(w[8*i +: 8]);
    chk(ev_overflow == ovf, "R5 overflow event", ev_overflow, ovf);
    chk(ev_illegal == bad, "R6 illegal event", ev_illegal, bad);
    check_state("write");
  endtask

  task automatic sw_read();
    bit bad, unf;
    logic [31:0] exp;
    @(negedge clk);
    bad = cmd_active && cmd_dir;
    unf = !bad && (q.size() < 4);
    if (q.size() >= 4) begin
      exp = {q[3], q[2], q[1], q[0]};
      chk(sw_rdata == exp, "R7 head word", sw_rdata, exp);
    end
    sw_rd_en = 1;
    #1 chk(tx_valid == 0, "R10 tx_valid during word read", tx_valid, 0);
    @(posedge clk); #1;
    sw_rd_en = 0;
    if (!bad && !unf) for (int i = 0; i < 4; i++) void'(q.pop_front());
    chk(ev_underflow == unf, "R4 underflow event", ev_underflow, unf);
    chk(ev_illegal == bad, "R6 illegal event", ev_illegal, bad);
    check_state("read");
  endtask

  task automatic rx_push(input logic [7:0] b);
    bit acc;
    @(negedge clk);
    rx_valid = 1; rx_byte = b;
    acc = q.size() < cap;
    #1 chk(rx_ready == acc, "R10 rx_ready", rx_ready, acc);
    @(posedge clk); #1;
    rx_valid = 0;
    if (acc) q.push_back(b);
    check_state("rx");
  endtask

  task automatic tx_pop();
    bit avail;
    @(negedge clk);
    tx_ready = 1;
    avail = q.size() != 0;
    #1 chk(tx_valid == avail, "R10 tx_valid", tx_valid, avail);
    if (avail) chk(tx_byte == q[0], "R7 tx byte order", tx_byte, q[0]);
    @(posedge clk); #1;
    tx_ready = 0;
    if (avail) void'(q.pop_front());
    check_state("tx");
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    duplex_full = m;
    sw_wr_en = 1; sw_wdata = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    sw_wr_en = 0;
    q.delete();
    cap = m ? 64 : 128;
    chk(ev_overflow == 0 && ev_illegal == 0, "R9 no event in flush cycle", ev_overflow, 0);
    check_state("R9 flush");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk(byte_count == 0 && space_left == 128, "R1 reset count/space", byte_count, 0);
    chk({ev_underflow, ev_overflow, ev_illegal} == 3'b000, "R1 reset events",
        {ev_underflow, ev_overflow, ev_illegal}, 0);
    check_state("R1");

    // half-duplex fill to overflow, then drain to underflow
    for (int i = 0; i <= 32; i++)
      sw_write({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
    rx_push(8'hAA);
    for (int i = 0; i <= 32; i++) sw_read();

    // byte packing both ways
    for (int k = 0; k < 7; k++) rx_push(8'(8'h10 + k));
    sw_read();
    sw_read();
    for (int k = 0; k < 4; k++) tx_pop();
    sw_write(32'hA3A2_A1A0);
    for (int k = 0; k < 5; k++) tx_pop();

    // wrong-direction accesses
    cmd_active = 1; cmd_dir = 0;
    sw_write(32'h1111_2222);
    for (int k = 0; k < 4; k++) rx_push(8'(8'h40 + k));
    cmd_dir = 1;
    sw_read();
    sw_write(32'h5555_6666);
    cmd_active = 0;

    // mode switch with data present
    set_mode(1'b1);
    for (int i = 0; i <= 16; i++) sw_write({8'(i), 8'(i ^ 8'h5A), 8'(i + 8'h80), 8'(~i)});
    rx_push(8'hBB);
    for (int i = 0; i <= 16; i++) sw_read();

    // threshold sweep over every count and threshold in full-duplex
    for (int n = 0; n <= 64; n++) begin
      for (int t = 0; t <= 64; t++) begin
        rd_thresh = 8'(t); wr_thresh = 8'(t);
        #0.05;
        chk(thr_rd == (n >= t), "R8 rd threshold sweep", thr_rd, n >= t);
        chk(thr_wr == (64 - n >= t), "R8 wr threshold sweep", thr_wr, 64 - n >= t);
      end
      rd_thresh = 8'd16; wr_thresh = 8'd40;
      if (n < 64) rx_push(8'(n));
    end
    rx_push(8'hCC);
    set_mode(1'b0);
    sw_write(32'h0BAD_F00D);
    sw_read();
    finish_run();
  end

endmodule